// File: doc/BRIEF.md
# Shared-Adder Priority Selector

This block chooses one of three sums by two prioritised condition flags and forms it with a single adder. The chosen sum is the first operand plus the second, the first plus the third, or the fourth operand incremented by one. It never builds three adders and a result multiplexer. Instead, a small priority decoder drives two operand multiplexers in front of one adder. The first multiplexer picks the augend from the first or the fourth operand. The second picks the addend from the second operand, the third operand or the constant one.

The adder output can be captured in one output register, or passed straight through, under a parameter. The sum keeps the operand width and wraps on overflow, and the carry is dropped. The block suits datapaths whose selection logic decides among a few related additions in the same cycle.

Top module: `shared_add_sel`

## Requirements
- R1: With `condFirst` = 1, the result is `opA + opB`.
- R2: With `condFirst` = 0 and `condSecond` = 1, the result is `opA + opC`.
- R3: With both flags 0, the result is `opD + 1`.
- R4: Every sum wraps modulo 2^WIDTH, and the carry out is discarded (for example 255 + 1 = 0 and 255 + 255 = 254 at WIDTH 8).
- R5: One adder serves all three cases. Exactly one addend source (opB, opC or the constant one) is selected at a time. The augend is `opD` exactly when the constant one is the addend.
- R6: With `REG_OUT` = 1 (the default), `result` shows the sum of the inputs present at a rising edge of `clk` from that edge on. It holds until the next edge, even if the inputs change.
- R7: While `rstN` is low, `result` is 0 (asynchronous, active-low reset of the output register).
- R8: `condFirst` overrides `condSecond`. When both are 1, the result is `opA + opB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| condFirst | input | 1 | Highest-priority selection flag |
| condSecond | input | 1 | Second selection flag |
| opA | input | WIDTH | Augend for the first two cases |
| opB | input | WIDTH | Addend when condFirst is set |
| opC | input | WIDTH | Addend when only condSecond is set |
| opD | input | WIDTH | Value incremented when no flag is set |
| result | output | WIDTH | Selected sum, registered when REG_OUT = 1 |

## Verification
In the default configuration, every sum is due at the first rising edge after its operands and flags are applied. No result is due earlier. The bench changes inputs on falling edges and reads `result` on the following falling edge, one register stage later. It also reads `result` right after an input change, before any edge, to confirm the previous sum is still held. The reset check reads `result` while `rstN` is low, with no edge required.

// File: rtl/shared_add_sel_pkg.sv
package shared_add_sel_pkg;

  // Addend source, one-hot: bit 0 = opB, bit 1 = opC, bit 2 = constant one.
  localparam int unsigned ADDEND_SRCS = 3;
  localparam int unsigned ADD_B   = 0;
  localparam int unsigned ADD_C   = 1;
  localparam int unsigned ADD_ONE = 2;

  typedef struct packed {
    logic                   augendIsD;
    logic [ADDEND_SRCS-1:0] addendSel;
  } opSel_t;

endpackage

// File: rtl/shared_add_sel_ctrl.sv
module shared_add_sel_ctrl
  import shared_add_sel_pkg::*;
(
  input  logic   condFirst,
  input  logic   condSecond,
  output opSel_t sel
);

  always_comb begin
    sel = '0;
    if (condFirst) begin
      sel.augendIsD        = 1'b0;
      sel.addendSel[ADD_B] = 1'b1;
    end else if (condSecond) begin
      sel.augendIsD        = 1'b0;
      sel.addendSel[ADD_C] = 1'b1;
    end else begin
      sel.augendIsD          = 1'b1;
      sel.addendSel[ADD_ONE] = 1'b1;
    end
  end

endmodule

// File: rtl/shared_add_sel_dp.sv
module shared_add_sel_dp
  import shared_add_sel_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  opSel_t           sel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [WIDTH-1:0] opD,
  output logic [WIDTH-1:0] sum
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] augend;
  logic [WIDTH-1:0] addend;

  assign augend = sel.augendIsD ? opD : opA;

  // AND-OR operand mux driven by the one-hot select.
  always_comb begin
    addend = '0;
    addend = addend | ({WIDTH{sel.addendSel[ADD_B]}}   & opB);
    addend = addend | ({WIDTH{sel.addendSel[ADD_C]}}   & opC);
    addend = addend | ({WIDTH{sel.addendSel[ADD_ONE]}} & ONE);
  end

  // The only adder; the carry is dropped by the width of the sum.
  assign sum = augend + addend;

endmodule

// File: rtl/shared_add_sel.sv
module shared_add_sel
  import shared_add_sel_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             condFirst,
  input  logic             condSecond,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [WIDTH-1:0] opD,
  output logic [WIDTH-1:0] result
);

  opSel_t           sel;
  logic [WIDTH-1:0] sum;

  shared_add_sel_ctrl u_ctrl (
    .condFirst  (condFirst),
    .condSecond (condSecond),
    .sel        (sel)
  );

  shared_add_sel_dp #(.WIDTH(WIDTH)) u_dp (
    .sel (sel),
    .opA (opA),
    .opB (opB),
    .opC (opC),
    .opD (opD),
    .sum (sum)
  );

  // Control-to-datapath strobes: one addend, augend paired with the increment (R5).
  p_addend_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(sel.addendSel));
  p_augend_pairing_r5: assert property (@(posedge clk) disable iff (!rstN)
    sel.augendIsD == sel.addendSel[ADD_ONE]);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) result <= '0;
        else       result <= sum;
      end

      p_first_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
        condFirst |=> result == WIDTH'($past(opA) + $past(opB)));
      p_second_sum_r2: assert property (@(posedge clk) disable iff (!rstN)
        (!condFirst && condSecond) |=> result == WIDTH'($past(opA) + $past(opC)));
      p_increment_r3: assert property (@(posedge clk) disable iff (!rstN)
        (!condFirst && !condSecond) |=> result == WIDTH'($past(opD) + WIDTH'(1)));
      p_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
        (condFirst && condSecond) |=> result == WIDTH'($past(opA) + $past(opB)));
    end else begin : g_comb
      assign result = sum;
    end
  endgenerate

endmodule

// File: tb/shared_add_sel_tb.sv
module shared_add_sel_tb;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         condFirst = 1'b0, condSecond = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shared_add_sel #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .condFirst(condFirst), .condSecond(condSecond),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD), .result(result)
  );

  // {condFirst, condSecond, a, b, c, d, expected}
  localparam int NV = 10;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {2'b10, 8'h10, 8'h20, 8'hFF, 8'h00, 8'h30},  // R1
    {2'b11, 8'h7F, 8'h01, 8'h55, 8'h00, 8'h80},  // R8
    {2'b01, 8'h12, 8'h99, 8'h34, 8'h00, 8'h46},  // R2
    {2'b00, 8'hAA, 8'hBB, 8'hCC, 8'h41, 8'h42},  // R3
    {2'b00, 8'h11, 8'h22, 8'h33, 8'hFF, 8'h00},  // R4
    {2'b10, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFE},  // R4
    {2'b01, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00},  // R4
    {2'b11, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00},  // R8
    {2'b00, 8'h5A, 8'h5A, 8'h5A, 8'h00, 8'h01},  // R3
    {2'b01, 8'h80, 8'h01, 8'h80, 8'h00, 8'h00}   // R2
  };

  function automatic logic [W-1:0] refSum(input logic f, input logic s,
      input logic [W-1:0] a, b, c, d);
    logic [W:0] full;
    if (f)      full = a + b;
    else if (s) full = a + c;
    else        full = d + 1;
    return full[W-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic apply(input logic f, input logic s, input logic [W-1:0] a, b, c, d);
    @(negedge clk);
    condFirst = f; condSecond = s; opA = a; opB = b; opC = c; opD = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset", '0);
    apply(1'b1, 1'b0, 8'h05, 8'h06, 8'h00, 8'h00);
    @(negedge clk);
    check("R7 held in reset", '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][41], VEC[i][40], VEC[i][39:32], VEC[i][31:24],
            VEC[i][23:16], VEC[i][15:8]);
      @(negedge clk);
      check($sformatf("vector %0d (R1 R2 R3 R4 R8)", i), VEC[i][7:0]);
    end

    // R6: the new inputs do not reach result before the next edge.
    apply(1'b1, 1'b0, 8'h01, 8'h02, 8'h00, 8'h00);
    @(negedge clk);
    check("R6 after edge", 8'h03);
    apply(1'b1, 1'b0, 8'h40, 8'h40, 8'h00, 8'h00);
    #1;
    check("R6 held before edge", 8'h03);
    @(negedge clk);
    check("R6 next edge", 8'h80);

    // Random operands over every flag combination, plus edge values.
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b, c, d;
      logic f, s;
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      if (i % 8 == 0) begin a = 8'hFF; b = 8'hFF; c = 8'h00; d = 8'hFF; end
      if (i % 8 == 1) begin a = 8'h00; b = 8'h00; c = 8'hFF; d = 8'h00; end
      f = i[1]; s = i[0];
      apply(f, s, a, b, c, d);
      @(negedge clk);
      check("random R1 R2 R3 R4 R8", refSum(f, s, a, b, c, d));
    end

    // R7: asynchronous clear mid-run.
    #1 rstN = 1'b0;
    #1 check("R7 async clear", '0);
    @(negedge clk);
    rstN = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: result=%h expected=completion", result);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule